// File: doc/BRIEF.md
# Radix-2^r Wide-Generate Carry Adder

This block is a purely combinational binary adder for operands of `WIDTH = 2^(RADIX_LOG*ROWS)` bits. From the two operands it forms per-bit propagate (`a ^ b`) and generate (`a & b`) signals. A chain of `ROWS` rows of wide generate gates, each of `2^RADIX_LOG` inputs, then resolves the carries. Row `l` gives every bit position the group generate over a window of `2^(RADIX_LOG*l)` positions, clipped at bit 0. A separate AND prefix network supplies the group propagate terms that each wide gate needs.

The block is placed inside a datapath wherever a low-depth adder with no carry-in is needed. The result is `WIDTH+1` bits wide, and its top bit is the carry-out. The default configuration (`RADIX_LOG = 2`, `ROWS = 2`) is a 16-bit adder.

Top module: `wide_carry_adder`

## Requirements
- R1: `sum_o` equals the unsigned sum of `a_i` and `b_i` as a `WIDTH+1`-bit value, for every operand pair.
- R2: `sum_o[WIDTH]` is 1 exactly when `a_i + b_i` is at least `2^WIDTH`.
- R3: The carry into bit 0 is fixed at zero: with both operands zero, `sum_o` is zero, and `sum_o[0]` always equals `a_i[0] ^ b_i[0]`.
- R4: A carry generated at bit 0 propagates through any run of propagating bits of length m (0 to `WIDTH`). For `a_i` equal to the low m bits set and `b_i = 1`, the result is `2^m`, including runs that cross the `2^RADIX_LOG` and `2^(2*RADIX_LOG)` window boundaries.
- R5: All-ones plus one gives `sum_o = 2^WIDTH`: every lower bit is 0 and the carry-out is 1.
- R6: Alternating bit patterns resolve correctly. Complementary alternating operands give all ones with no carry-out, and identical alternating operands give their doubled value.
- R7: When a window is already complete at the previous row because it is clipped at bit 0, the row passes that generate on unchanged. Sums whose carries come only from low positions are therefore exact.
- R8: The parameters must satisfy `WIDTH == 2^(RADIX_LOG*ROWS)` with both exponents at least 1. Any other combination stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| sum_o | output | WIDTH+1 | Sum; the top bit is the carry-out |

## Verification
The adder is driven with both operands zero, which tests the fixed zero carry-in. It is driven with all ones plus one, where a single carry ripples through every row and out of the top. Complementary alternating words propagate everywhere but generate nowhere. Identical alternating words generate at every other bit.

A sweep of single-carry propagate runs of each length 0 to `WIDTH` shows whether windows that are clipped at bit 0, and spans that cross row boundaries, are combined in the right order. Random operand pairs then cover mixed generate and kill patterns against the behavioural sum.

// File: rtl/adder_pkg.sv
package adder_pkg;

    // Carry-resolution pair for one bit position
    typedef struct packed {
        logic prop;
        logic gen;
    } gp_t;

    // Window length covered by a given row
    function automatic int unsigned span_len(input int unsigned radix_log,
                                             input int unsigned row);
        return 1 << (radix_log * row);
    endfunction

endpackage

// File: rtl/gp_prep.sv
module gp_prep
    import adder_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output gp_t  [WIDTH-1:0] gp_o
);
    for (genvar t = 0; t < WIDTH; t++) begin : g_bit
        assign gp_o[t].prop = a_i[t] ^ b_i[t];
        assign gp_o[t].gen  = a_i[t] & b_i[t];
    end
endmodule

// File: rtl/and_prefix_net.sv
// AND prefix network: level s holds, per position t, the AND of propagates
// over max(0, t-2^s+1) .. t. Every RADIX_LOG levels a span is tapped out.
module and_prefix_net #(
    parameter int WIDTH     = 16,
    parameter int RADIX_LOG = 2,
    parameter int ROWS      = 2
) (
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH-1:0] span_o [ROWS]
);
    localparam int STEPS = RADIX_LOG * (ROWS - 1);

    logic [WIDTH-1:0] lvl [STEPS+1];

    assign lvl[0] = prop_i;

    for (genvar s = 1; s <= STEPS; s++) begin : g_lvl
        localparam int DIST = 1 << (s - 1);
        for (genvar t = 0; t < WIDTH; t++) begin : g_pos
            if (t >= DIST) begin : g_and
                assign lvl[s][t] = lvl[s-1][t] & lvl[s-1][t-DIST];
            end else begin : g_pass
                assign lvl[s][t] = lvl[s-1][t];
            end
        end
    end

    for (genvar l = 0; l < ROWS; l++) begin : g_tap
        assign span_o[l] = lvl[RADIX_LOG*l];
    end
endmodule

// File: rtl/wide_gen_gate.sv
// Group generate of FANIN ordered spans; index 0 is the most significant.
module wide_gen_gate #(
    parameter int FANIN = 4
) (
    input  logic [FANIN-1:0] gen_i,
    input  logic [FANIN-1:0] prop_i,
    output logic             gen_o
);
    logic             [FANIN-1:0] pass_above;
    logic             [FANIN-1:0] minterm;

    // suffix AND of the more significant span propagates
    assign pass_above[0] = 1'b1;
    for (genvar j = 1; j < FANIN; j++) begin : g_suffix
        assign pass_above[j] = pass_above[j-1] & prop_i[j-1];
    end

    for (genvar j = 0; j < FANIN; j++) begin : g_min
        assign minterm[j] = gen_i[j] & pass_above[j];
    end

    assign gen_o = |minterm;
endmodule

// File: rtl/wide_carry_adder.sv
module wide_carry_adder
    import adder_pkg::*;
#(
    parameter int RADIX_LOG = 2,
    parameter int ROWS      = 2,
    parameter int WIDTH     = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH:0]   sum_o
);
    localparam int FANIN = 1 << RADIX_LOG;

    // R8: structural consistency of the parameters
    if (RADIX_LOG < 1 || ROWS < 1 || WIDTH != (1 << (RADIX_LOG * ROWS))) begin : g_bad_cfg
        $error("wide_carry_adder: WIDTH must equal 2**(RADIX_LOG*ROWS)");
    end

    gp_t  [WIDTH-1:0] gp;
    logic [WIDTH-1:0] prop_bits;
    logic [WIDTH-1:0] prop_span [ROWS];
    logic [WIDTH-1:0] gen_row   [ROWS+1];
    logic [WIDTH:0]   carry;

    gp_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i  (a_i),
        .b_i  (b_i),
        .gp_o (gp)
    );

    for (genvar t = 0; t < WIDTH; t++) begin : g_unpack
        assign prop_bits[t]  = gp[t].prop;
        assign gen_row[0][t] = gp[t].gen;
    end

    and_prefix_net #(
        .WIDTH     (WIDTH),
        .RADIX_LOG (RADIX_LOG),
        .ROWS      (ROWS)
    ) u_and_net (
        .prop_i (prop_bits),
        .span_o (prop_span)
    );

    for (genvar l = 1; l <= ROWS; l++) begin : g_row
        localparam int SUB = 1 << (RADIX_LOG * (l - 1));
        for (genvar t = 0; t < WIDTH; t++) begin : g_pos
            if (t < SUB) begin : g_buf
                // window already clipped at bit 0 in the previous row (R7)
                assign gen_row[l][t] = gen_row[l-1][t];
            end else begin : g_gate
                logic [FANIN-1:0] sub_gen;
                logic [FANIN-1:0] sub_prop;
                for (genvar j = 0; j < FANIN; j++) begin : g_in
                    if (t >= j * SUB) begin : g_live
                        assign sub_gen[j]  = gen_row[l-1][t-j*SUB];
                        assign sub_prop[j] = prop_span[l-1][t-j*SUB];
                    end else begin : g_off
                        assign sub_gen[j]  = 1'b0;
                        assign sub_prop[j] = 1'b0;
                    end
                end
                wide_gen_gate #(.FANIN(FANIN)) u_gate (
                    .gen_i  (sub_gen),
                    .prop_i (sub_prop),
                    .gen_o  (gen_row[l][t])
                );
            end
        end
    end

    // R3: no carry-in
    assign carry[0] = 1'b0;
    for (genvar t = 0; t < WIDTH; t++) begin : g_sum
        assign carry[t+1] = gen_row[ROWS][t];
        assign sum_o[t]   = prop_bits[t] ^ carry[t];
    end
    assign sum_o[WIDTH] = carry[WIDTH];
endmodule

// File: rtl/wide_carry_adder_chk.sv
module wide_carry_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH:0]   sum_o
);
    logic [WIDTH:0] ref_sum;
    logic           known;

    assign ref_sum = {1'b0, a_i} + {1'b0, b_i};
    assign known   = !$isunknown({a_i, b_i, sum_o});

    always_comb begin
        if (known) begin
            AST_SUM_MATCH: assert (sum_o == ref_sum);                                  // R1
            AST_CARRY_OUT: assert (sum_o[WIDTH] == (ref_sum >= (WIDTH+1)'(1) << WIDTH)); // R2
            AST_LSB_NO_CIN: assert (sum_o[0] == (a_i[0] ^ b_i[0]));                     // R3
            if (&a_i && b_i == WIDTH'(1))
                AST_FULL_RIPPLE: assert (sum_o == ((WIDTH+1)'(1) << WIDTH));            // R5
            if ((a_i & b_i) == '0)
                AST_NO_GEN_NO_CARRY: assert (sum_o == {1'b0, a_i | b_i});               // R6
        end
    end
endmodule

bind wide_carry_adder wide_carry_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o)
);

// File: tb/sim_wide_carry_adder.sv
`timescale 1ns/1ps
module sim_wide_carry_adder;
    localparam int RL = 2;
    localparam int RW = 2;
    localparam int N  = 1 << (RL * RW);

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [N-1:0] a, b;
    logic [N:0]   sum;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    wide_carry_adder #(.RADIX_LOG(RL), .ROWS(RW), .WIDTH(N)) u0 (
        .a_i   (a),
        .b_i   (b),
        .sum_o (sum)
    );

    task automatic chk(input string req, input logic [N:0] act, input logic [N:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, a, b);
        end
    endtask

    // apply operands after a rising edge, sample at the falling edge
    task automatic apply(input logic [N-1:0] av, input logic [N-1:0] bv);
        @(posedge clk);
        a = av;
        b = bv;
        @(negedge clk);
    endtask

    function automatic logic [N:0] model(input logic [N-1:0] x, input logic [N-1:0] y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    task automatic t_zero();                 // R3
        apply('0, '0);
        chk("R3 zero operands", sum, '0);
        apply(N'(1), '0);
        chk("R3 lsb without carry-in", {{N{1'b0}}, sum[0]}, (N+1)'(1));
    endtask

    task automatic t_all_ones();             // R5, R2
        apply('1, N'(1));
        chk("R5 all ones plus one", sum, (N+1)'(1) << N);
        chk("R2 carry-out set", {{N{1'b0}}, sum[N]}, (N+1)'(1));
        apply('1, '1);
        chk("R1 all ones doubled", sum, model('1, '1));
    endtask

    task automatic t_alternating();          // R6
        logic [N-1:0] alt;
        alt = '0;
        for (int i = 0; i < N; i += 2) alt[i+1] = 1'b1;
        apply(alt, ~alt);
        chk("R6 complementary alternating", sum, {1'b0, {N{1'b1}}});
        apply(alt, alt);
        chk("R6 identical alternating", sum, model(alt, alt));
        apply(~alt, ~alt);
        chk("R6 identical inverted alternating", sum, model(~alt, ~alt));
    endtask

    task automatic t_runs();                 // R4, R7
        for (int m = 0; m <= N; m++) begin
            logic [N-1:0] run;
            run = (m == N) ? '1 : N'((N+1)'(1) << m) - N'(1);
            apply(run, N'(1));
            chk("R4 propagate run", sum, (N+1)'(1) << m);
        end
        for (int p = 0; p < N; p++) begin
            apply(N'(1) << p, N'(1) << p);
            chk("R7 single generate", sum, (N+1)'(1) << (p + 1));
        end
    endtask

    task automatic t_random();               // R1, R2
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] av, bv;
            av = N'($urandom);
            bv = N'($urandom);
            apply(av, bv);
            chk("R1 random sum", sum, model(av, bv));
            chk("R2 random carry-out", {{N{1'b0}}, sum[N]},
                {{N{1'b0}}, model(av, bv) >= ((N+1)'(1) << N)});
        end
    endtask

    initial begin
        a = '0;
        b = '0;
        repeat (2) @(posedge clk);
        t_zero();
        t_all_ones();
        t_alternating();
        t_runs();
        t_random();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule